// File: doc/BRIEF.md
# Queue Enable Sequencer with Context Fetch

This block runs the bring-up and tear-down of a bank of receive and transmit descriptor rings. Software raises a per-ring request bit. The sequencer then reads that ring's context record from host memory and decodes the ring parameters from it. Only then does it report the ring as running through a status bit. Dropping the request stops the ring at once. Doorbell (tail-pointer) writes pass on to the descriptor engine only for rings that are running.

There are `NQ` receive rings and `NQ` transmit rings, and `NQ` is a power of two. All rings share one read channel toward host memory, and at most one context read is in flight at any time. The contexts of each direction sit in one table that starts at a 512-byte-aligned block number. Receive records are 32 bytes apart and transmit records are 128 bytes apart. The response carries the first 32 bytes of the record. When a ring starts, the decoded parameters come out as a one-cycle configuration pulse. A record that asks for an unsupported mode leaves its ring stopped and raises that ring's error flag instead.

Top module: `qena_seq`

## Requirements
- R1: After reset every status flag, every error flag, `rd_req_valid`, `tail_note_valid` and `cfg_valid` is 0. A ring's status flag is 1 exactly while the ring is running.
- R2: A request bit that is high on a ring that is idle produces exactly one context read. While that ring is fetching or running, holding the request high produces no further read.
- R3: The read address is `base_blk*512 + idx*32` for a receive ring and `base_blk*512 + idx*128` for a transmit ring. `rd_req_len` is 32 or 128 to match. The block holds the address and length stable from the cycle `rd_req_valid` rises until the cycle `rd_req_ready` accepts the request.
- R4: A response can only arrive after its request has been accepted. On the clock edge that takes a valid response for a live fetch of a supported record, the ring's status flag rises. In the same cycle `cfg_valid` pulses for one cycle with `cfg_is_rx` and `cfg_idx` naming the ring.
- R5: The fields common to both directions are decoded as follows. Head is context bits [12:0]. Ring base is bits [88:32] times 128. Ring length is bits [101:89] for receive and bits [173:161] for transmit.
- R6: The receive-only fields are decoded as follows. Data buffer size is bits [108:102] times 128. Header buffer size is bits [113:109] times 64. Descriptor type is bits [115:114]. The 32-byte descriptor flag is bit 116. The CRC-strip flag is bit 117. Maximum frame size is bits [187:174] times 128.
- R7: For transmit, bit 160 enables head write-back, and the write-back address is bits [255:192].
- R8: Some records are unsupported:
  - a receive record with bit 116 = 0;
  - a receive record with a nonzero descriptor type;
  - a transmit record with bit 160 = 0.
  
  Such a record sets the ring's error flag instead of its status flag, and `cfg_valid` stays low. The error flag clears one cycle after the request drops.
- R9: When the request of a running ring drops, its status flag is 0 from the next cycle, and no memory read is issued.
- R10: A tail write raises `tail_note_valid` one cycle later, with the same direction and index, only if the addressed ring's status was 1 before that clock edge. A tail write in the cycle the ring's response lands is therefore not forwarded.
- R11: Rings waiting to start are served one read at a time in the order rx0, tx0, rx1, tx1, and so on (the lowest index first, receive before transmit at equal index).
- R12: If the request drops while a ring is fetching, the ring returns to idle. The response that follows is discarded: no status, no error and no `cfg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | NQ | Per-ring start request, receive |
| tx_req | input | NQ | Per-ring start request, transmit |
| rx_stat | output | NQ | Receive ring running |
| tx_stat | output | NQ | Transmit ring running |
| rx_err | output | NQ | Receive ring rejected its context |
| tx_err | output | NQ | Transmit ring rejected its context |
| rx_base_blk | input | BASE_W | Receive context table start, in 512-byte blocks |
| tx_base_blk | input | BASE_W | Transmit context table start, in 512-byte blocks |
| tail_wr_valid | input | 1 | Doorbell write strobe |
| tail_wr_is_rx | input | 1 | Doorbell targets a receive ring |
| tail_wr_idx | input | QIW | Doorbell ring index |
| tail_note_valid | output | 1 | Doorbell forwarded to descriptor engine |
| tail_note_is_rx | output | 1 | Direction of forwarded doorbell |
| tail_note_idx | output | QIW | Index of forwarded doorbell |
| rd_req_valid | output | 1 | Context read request valid |
| rd_req_ready | input | 1 | Context read request accepted |
| rd_req_addr | output | AW | Context byte address |
| rd_req_len | output | 8 | Context length in bytes |
| rd_rsp_valid | input | 1 | Context read data valid |
| rd_rsp_data | input | 256 | First 32 bytes of the context record |
| cfg_valid | output | 1 | Ring started, parameters valid |
| cfg_is_rx | output | 1 | Started ring is receive |
| cfg_idx | output | QIW | Started ring index |
| cfg_head | output | 13 | Initial head |
| cfg_ring_base | output | 64 | Ring byte base |
| cfg_ring_len | output | 13 | Ring length in descriptors |
| cfg_buf_data | output | 16 | Receive data buffer bytes |
| cfg_buf_hdr | output | 16 | Receive header buffer bytes |
| cfg_desc_type | output | 2 | Receive descriptor type |
| cfg_desc32 | output | 1 | 32-byte descriptors |
| cfg_crc_strip | output | 1 | Strip CRC on receive |
| cfg_max_frame | output | 21 | Receive maximum frame bytes |
| cfg_hwb_addr | output | 64 | Transmit head write-back address |

## Verification
The two functions that can meet on one edge are the arrival of a context response and a doorbell write for the same ring. Doorbell gating uses the status held before the edge, so the bench drives a tail write to receive ring 1 in the very cycle its response is presented. It expects no forwarded doorbell in the next cycle, even though the status flag has just risen. A second doorbell one cycle later must then be forwarded. The bench also checks a request dropped between the accepted read and its response (the fetch must be discarded), and the full-bank start-up, where the read addresses reveal the service order.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    localparam int CTX_W      = 256;
    localparam int BLK_SHIFT  = 9;
    localparam int RX_CTX_SH  = 5;
    localparam int TX_CTX_SH  = 7;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_FETCH = 2'd1,
        Q_ON    = 2'd2,
        Q_FAULT = 2'd3
    } qstate_e;

    typedef struct packed {
        logic [12:0] head;
        logic [63:0] ring_base;
        logic [12:0] ring_len;
        logic [15:0] buf_data;
        logic [15:0] buf_hdr;
        logic [1:0]  desc_type;
        logic        desc32;
        logic        crc_strip;
        logic [20:0] max_frame;
        logic        hwb;
        logic [63:0] hwb_addr;
        logic        ok;
    } ring_cfg_t;

endpackage

// File: rtl/qseq_ctx_decode.sv
module qseq_ctx_decode
    import qseq_pkg::*;
(
    input  logic             is_rx,
    input  logic [CTX_W-1:0] ctx,
    output ring_cfg_t        cfg
);

    logic unused_ctx;
    assign unused_ctx = ^{ctx[31:13], ctx[159:118], ctx[191:188]};

    always_comb begin
        cfg = '0;
        cfg.head      = ctx[12:0];
        cfg.ring_base = {ctx[88:32], 7'b0};
        if (is_rx) begin
            cfg.ring_len  = ctx[101:89];
            cfg.buf_data  = {2'b0, ctx[108:102], 7'b0};
            cfg.buf_hdr   = {5'b0, ctx[113:109], 6'b0};
            cfg.desc_type = ctx[115:114];
            cfg.desc32    = ctx[116];
            cfg.crc_strip = ctx[117];
            cfg.max_frame = {ctx[187:174], 7'b0};
            cfg.ok        = ctx[116] && (ctx[115:114] == 2'b00);
        end else begin
            cfg.ring_len  = ctx[173:161];
            cfg.hwb       = ctx[160];
            cfg.hwb_addr  = ctx[255:192];
            cfg.ok        = ctx[160];
        end
    end

endmodule

// File: rtl/qseq_pick.sv
module qseq_pick #(
    parameter  int N  = 8,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  want,
    output logic          found,
    output logic [SW-1:0] slot
);

    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) begin
                found = 1'b1;
                slot  = SW'(i);
            end
        end
    end

endmodule

// File: rtl/qena_seq.sv
module qena_seq
    import qseq_pkg::*;
#(
    parameter  int NQ     = 4,
    parameter  int AW     = 64,
    parameter  int BASE_W = 13,
    localparam int QIW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NQ-1:0]     rx_req,
    input  logic [NQ-1:0]     tx_req,
    output logic [NQ-1:0]     rx_stat,
    output logic [NQ-1:0]     tx_stat,
    output logic [NQ-1:0]     rx_err,
    output logic [NQ-1:0]     tx_err,
    input  logic [BASE_W-1:0] rx_base_blk,
    input  logic [BASE_W-1:0] tx_base_blk,
    input  logic              tail_wr_valid,
    input  logic              tail_wr_is_rx,
    input  logic [QIW-1:0]    tail_wr_idx,
    output logic              tail_note_valid,
    output logic              tail_note_is_rx,
    output logic [QIW-1:0]    tail_note_idx,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [AW-1:0]     rd_req_addr,
    output logic [7:0]        rd_req_len,
    input  logic              rd_rsp_valid,
    input  logic [CTX_W-1:0]  rd_rsp_data,
    output logic              cfg_valid,
    output logic              cfg_is_rx,
    output logic [QIW-1:0]    cfg_idx,
    output logic [12:0]       cfg_head,
    output logic [63:0]       cfg_ring_base,
    output logic [12:0]       cfg_ring_len,
    output logic [15:0]       cfg_buf_data,
    output logic [15:0]       cfg_buf_hdr,
    output logic [1:0]        cfg_desc_type,
    output logic              cfg_desc32,
    output logic              cfg_crc_strip,
    output logic [20:0]       cfg_max_frame,
    output logic [63:0]       cfg_hwb_addr
);

    localparam int NS = 2 * NQ;
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        qstate_e [NQ-1:0] rx_st;
        qstate_e [NQ-1:0] tx_st;
        logic             busy;
        logic             sent;
        logic             cur_rx;
        logic [QIW-1:0]   cur_idx;
        logic [AW-1:0]    addr;
        logic [7:0]       len;
        logic             note_v;
        logic             note_rx;
        logic [QIW-1:0]   note_idx;
        logic             cfg_v;
        logic             cfg_rx;
        logic [QIW-1:0]   cfg_idx;
        ring_cfg_t        cfg;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [NS-1:0] want;
    logic          found;
    logic [SW-1:0] slot;
    ring_cfg_t     dec;

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_want
            assign want[2*i]   = rx_req[i] && (st_q.rx_st[i] == Q_IDLE);
            assign want[2*i+1] = tx_req[i] && (st_q.tx_st[i] == Q_IDLE);
            assign rx_stat[i]  = (st_q.rx_st[i] == Q_ON);
            assign tx_stat[i]  = (st_q.tx_st[i] == Q_ON);
            assign rx_err[i]   = (st_q.rx_st[i] == Q_FAULT);
            assign tx_err[i]   = (st_q.tx_st[i] == Q_FAULT);
        end
    endgenerate

    qseq_pick #(.N(NS)) i_pick (
        .want  (want),
        .found (found),
        .slot  (slot)
    );

    qseq_ctx_decode i_decode (
        .is_rx (st_q.cur_rx),
        .ctx   (rd_rsp_data),
        .cfg   (dec)
    );

    always_comb begin
        logic live;
        logic [QIW-1:0] nidx;
        st_d        = st_q;
        st_d.note_v = 1'b0;
        st_d.cfg_v  = 1'b0;
        live        = 1'b0;
        nidx        = '0;

        // request released: any non-idle ring returns to idle
        for (int i = 0; i < NQ; i++) begin
            if (!rx_req[i] && st_q.rx_st[i] != Q_IDLE) st_d.rx_st[i] = Q_IDLE;
            if (!tx_req[i] && st_q.tx_st[i] != Q_IDLE) st_d.tx_st[i] = Q_IDLE;
        end

        if (st_q.busy && !st_q.sent && rd_req_ready) st_d.sent = 1'b1;

        if (st_q.busy && st_q.sent && rd_rsp_valid) begin
            st_d.busy = 1'b0;
            st_d.sent = 1'b0;
            if (st_q.cur_rx) begin
                live = (st_q.rx_st[st_q.cur_idx] == Q_FETCH) && rx_req[st_q.cur_idx];
                if (live) st_d.rx_st[st_q.cur_idx] = dec.ok ? Q_ON : Q_FAULT;
            end else begin
                live = (st_q.tx_st[st_q.cur_idx] == Q_FETCH) && tx_req[st_q.cur_idx];
                if (live) st_d.tx_st[st_q.cur_idx] = dec.ok ? Q_ON : Q_FAULT;
            end
            st_d.cfg_v   = live && dec.ok;
            st_d.cfg_rx  = st_q.cur_rx;
            st_d.cfg_idx = st_q.cur_idx;
            st_d.cfg     = dec;
        end

        if (!st_q.busy && found) begin
            nidx         = QIW'(slot >> 1);
            st_d.busy    = 1'b1;
            st_d.sent    = 1'b0;
            st_d.cur_rx  = !slot[0];
            st_d.cur_idx = nidx;
            if (!slot[0]) begin
                st_d.rx_st[nidx] = Q_FETCH;
                st_d.addr = (AW'(rx_base_blk) << BLK_SHIFT) + (AW'(nidx) << RX_CTX_SH);
                st_d.len  = 8'd32;
            end else begin
                st_d.tx_st[nidx] = Q_FETCH;
                st_d.addr = (AW'(tx_base_blk) << BLK_SHIFT) + (AW'(nidx) << TX_CTX_SH);
                st_d.len  = 8'd128;
            end
        end

        if (tail_wr_valid) begin
            st_d.note_v   = tail_wr_is_rx ? (st_q.rx_st[tail_wr_idx] == Q_ON)
                                          : (st_q.tx_st[tail_wr_idx] == Q_ON);
            st_d.note_rx  = tail_wr_is_rx;
            st_d.note_idx = tail_wr_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_valid    = st_q.busy && !st_q.sent;
    assign rd_req_addr     = st_q.addr;
    assign rd_req_len      = st_q.len;
    assign tail_note_valid = st_q.note_v;
    assign tail_note_is_rx = st_q.note_rx;
    assign tail_note_idx   = st_q.note_idx;
    assign cfg_valid       = st_q.cfg_v;
    assign cfg_is_rx       = st_q.cfg_rx;
    assign cfg_idx         = st_q.cfg_idx;
    assign cfg_head        = st_q.cfg.head;
    assign cfg_ring_base   = st_q.cfg.ring_base;
    assign cfg_ring_len    = st_q.cfg.ring_len;
    assign cfg_buf_data    = st_q.cfg.buf_data;
    assign cfg_buf_hdr     = st_q.cfg.buf_hdr;
    assign cfg_desc_type   = st_q.cfg.desc_type;
    assign cfg_desc32      = st_q.cfg.desc32;
    assign cfg_crc_strip   = st_q.cfg.crc_strip;
    assign cfg_max_frame   = st_q.cfg.max_frame;
    assign cfg_hwb_addr    = st_q.cfg.hwb_addr;

    logic unused_cfg;
    assign unused_cfg = st_q.cfg.hwb ^ st_q.cfg.ok;

    // ---------------- assertions ----------------
    logic [NS-1:0] fetching;
    logic          tail_target_on;
    assign tail_target_on = tail_wr_is_rx ? rx_stat[tail_wr_idx] : tx_stat[tail_wr_idx];

    generate
        for (genvar i = 0; i < NQ; i++) begin : g_chk
            assign fetching[2*i]   = (st_q.rx_st[i] == Q_FETCH);
            assign fetching[2*i+1] = (st_q.tx_st[i] == Q_FETCH);

            // R4
            rx_on_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rx_stat[i]) |-> $past(rd_rsp_valid) && $past(rx_req[i]));
            // R4
            tx_on_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(tx_stat[i]) |-> $past(rd_rsp_valid) && $past(tx_req[i]));
            // R8
            rx_err_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rx_err[i]) |-> $past(rd_rsp_valid));
            // R9
            rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rx_stat[i] && !rx_req[i] |=> !rx_stat[i]);
            // R9
            tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tx_stat[i] && !tx_req[i] |=> !tx_stat[i]);
        end
    endgenerate

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));
    // R11
    one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fetching) <= 1);
    // R10
    tail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_wr_valid && !tail_target_on |=> !tail_note_valid);
    // R4
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(rd_rsp_valid));

endmodule

// File: tb/test_qena_seq.sv
`timescale 1ns/1ps
module test_qena_seq;

    localparam int NQ = 4;
    localparam logic [12:0] RXB = 13'h0123;
    localparam logic [12:0] TXB = 13'h0456;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NQ-1:0] rx_req = '0, tx_req = '0;
    logic [NQ-1:0] rx_stat, tx_stat, rx_err, tx_err;
    logic tail_wr_valid = 1'b0, tail_wr_is_rx = 1'b0;
    logic [1:0] tail_wr_idx = '0;
    logic tail_note_valid, tail_note_is_rx;
    logic [1:0] tail_note_idx;
    logic rd_req_valid, rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic [7:0] rd_req_len;
    logic rd_rsp_valid = 1'b0;
    logic [255:0] rd_rsp_data = '0;
    logic cfg_valid, cfg_is_rx, cfg_desc32, cfg_crc_strip;
    logic [1:0] cfg_idx, cfg_desc_type;
    logic [12:0] cfg_head, cfg_ring_len;
    logic [63:0] cfg_ring_base, cfg_hwb_addr;
    logic [15:0] cfg_buf_data, cfg_buf_hdr;
    logic [20:0] cfg_max_frame;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qena_seq #(.NQ(NQ), .AW(64), .BASE_W(13)) i_qena_seq (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
        .rx_stat(rx_stat), .tx_stat(tx_stat), .rx_err(rx_err), .tx_err(tx_err),
        .rx_base_blk(RXB), .tx_base_blk(TXB),
        .tail_wr_valid(tail_wr_valid), .tail_wr_is_rx(tail_wr_is_rx), .tail_wr_idx(tail_wr_idx),
        .tail_note_valid(tail_note_valid), .tail_note_is_rx(tail_note_is_rx), .tail_note_idx(tail_note_idx),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_req_len(rd_req_len), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .cfg_valid(cfg_valid), .cfg_is_rx(cfg_is_rx), .cfg_idx(cfg_idx), .cfg_head(cfg_head),
        .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len), .cfg_buf_data(cfg_buf_data),
        .cfg_buf_hdr(cfg_buf_hdr), .cfg_desc_type(cfg_desc_type), .cfg_desc32(cfg_desc32),
        .cfg_crc_strip(cfg_crc_strip), .cfg_max_frame(cfg_max_frame), .cfg_hwb_addr(cfg_hwb_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-ring field values chosen by the bench
    function automatic logic [12:0] f_head(bit rx, int q);  return 13'(100 + q * 7 + int'(rx)); endfunction
    function automatic logic [56:0] f_base(bit rx, int q);  return 57'h1_2345_6789 + 57'(q * 16) + 57'(rx); endfunction
    function automatic logic [12:0] f_len(bit rx, int q);   return 13'(64 + q * 2 + int'(rx)); endfunction
    function automatic logic [6:0]  f_dbuf(int q);          return 7'(5 + q); endfunction
    function automatic logic [4:0]  f_hbuf(int q);          return 5'(2 + q); endfunction
    function automatic logic [13:0] f_maxf(int q);          return 14'(1000 + q); endfunction
    function automatic logic [63:0] f_hwba(int q);          return 64'hABCD_0000_0000_0100 + 64'(q); endfunction

    function automatic logic [255:0] mk_ctx(bit rx, int q, bit lng, logic [1:0] dt, bit hwb);
        logic [255:0] c = '0;
        c[12:0]  = f_head(rx, q);
        c[88:32] = f_base(rx, q);
        if (rx) begin
            c[101:89]  = f_len(rx, q);
            c[108:102] = f_dbuf(q);
            c[113:109] = f_hbuf(q);
            c[115:114] = dt;
            c[116]     = lng;
            c[117]     = q[0];
            c[187:174] = f_maxf(q);
        end else begin
            c[160]     = hwb;
            c[173:161] = f_len(rx, q);
            c[255:192] = f_hwba(q);
        end
        return c;
    endfunction

    task automatic wait_rd(output bit seen);
        seen = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (rd_req_valid) seen = 1;
            else @(negedge clk);
        end
    endtask

    // serve one context read; checks address (R3), decode (R4..R7) or rejection (R8)
    task automatic serve(input bit rx, input int q, input logic [255:0] ctx, input bit ok, input bit tail_mid);
        bit seen;
        logic [63:0] ea;
        wait_rd(seen);
        check("R2 read issued", 64'(seen), 64'd1);
        ea = rx ? (64'(RXB) * 512 + 64'(q) * 32) : (64'(TXB) * 512 + 64'(q) * 128);
        check("R3/R11 read address", rd_req_addr, ea);
        check("R3 read length", 64'(rd_req_len), rx ? 64'd32 : 64'd128);
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        check("R2 single read", 64'(rd_req_valid), 64'd0);
        repeat (2) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = ctx;
        if (tail_mid) begin
            tail_wr_valid = 1'b1; tail_wr_is_rx = rx; tail_wr_idx = 2'(q);
        end
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        tail_wr_valid = 1'b0;
        if (tail_mid) check("R10 tail in response cycle not forwarded", 64'(tail_note_valid), 64'd0);
        check("R4 cfg_valid", 64'(cfg_valid), 64'(ok));
        check("R4/R8 status", 64'(rx ? rx_stat[q] : tx_stat[q]), 64'(ok));
        check("R8 error flag", 64'(rx ? rx_err[q] : tx_err[q]), 64'(!ok));
        if (ok) begin
            check("R4 cfg_is_rx", 64'(cfg_is_rx), 64'(rx));
            check("R4 cfg_idx", 64'(cfg_idx), 64'(q));
            check("R5 head", 64'(cfg_head), 64'(f_head(rx, q)));
            check("R5 ring base", cfg_ring_base, 64'(f_base(rx, q)) * 128);
            check("R5 ring length", 64'(cfg_ring_len), 64'(f_len(rx, q)));
            if (rx) begin
                check("R6 data buffer", 64'(cfg_buf_data), 64'(f_dbuf(q)) * 128);
                check("R6 header buffer", 64'(cfg_buf_hdr), 64'(f_hbuf(q)) * 64);
                check("R6 desc32", 64'(cfg_desc32), 64'd1);
                check("R6 crc strip", 64'(cfg_crc_strip), 64'(q % 2));
                check("R6 max frame", 64'(cfg_max_frame), 64'(f_maxf(q)) * 128);
            end else begin
                check("R7 write-back address", cfg_hwb_addr, f_hwba(q));
                check("R7 desc32 clear for tx", 64'(cfg_desc32), 64'd0);
            end
        end
    endtask

    task automatic tail(input bit rx, input int q, input bit exp);
        tail_wr_valid = 1'b1; tail_wr_is_rx = rx; tail_wr_idx = 2'(q);
        @(negedge clk);
        tail_wr_valid = 1'b0;
        check("R10 tail forwarded", 64'(tail_note_valid), 64'(exp));
        if (exp) begin
            check("R10 tail direction", 64'(tail_note_is_rx), 64'(rx));
            check("R10 tail index", 64'(tail_note_idx), 64'(q));
        end
    endtask

    task automatic no_reads(input int n, input string tag);
        int cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rd_req_valid) cnt++;
        end
        check(tag, 64'(cnt), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset rx_stat", 64'(rx_stat), 64'd0);
        check("R1 reset tx_stat", 64'(tx_stat), 64'd0);
        check("R1 reset errors", 64'({rx_err, tx_err}), 64'd0);
        check("R1 reset outputs", 64'({rd_req_valid, tail_note_valid, cfg_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every ring, one at a time
        for (int q = 0; q < NQ; q++) begin
            for (int r = 1; r >= 0; r--) begin
                if (r == 1) rx_req[q] = 1'b1; else tx_req[q] = 1'b1;
                serve(r == 1, q, mk_ctx(r == 1, q, 1'b1, 2'b00, 1'b1), 1'b1, 1'b0);
            end
        end
        no_reads(5, "R2 no reread while running");
        check("R1 all running rx", 64'(rx_stat), 64'hF);
        check("R1 all running tx", 64'(tx_stat), 64'hF);

        // tail forwarding on every running ring
        for (int q = 0; q < NQ; q++) begin
            tail(1'b1, q, 1'b1);
            tail(1'b0, q, 1'b1);
        end

        // R9 disable at once
        rx_req[1] = 1'b0; tx_req[2] = 1'b0;
        @(negedge clk);
        check("R9 rx1 stopped", 64'(rx_stat), 64'hD);
        check("R9 tx2 stopped", 64'(tx_stat), 64'hB);
        no_reads(3, "R9 no traffic on disable");
        tail(1'b1, 1, 1'b0);
        tail(1'b0, 2, 1'b0);

        // R10 tail in the same cycle as the response
        rx_req[1] = 1'b1;
        serve(1'b1, 1, mk_ctx(1'b1, 1, 1'b1, 2'b00, 1'b1), 1'b1, 1'b1);
        tail(1'b1, 1, 1'b1);

        // R11 ordering with unsupported records mixed in (R8)
        rx_req = '0; tx_req = '0;
        repeat (2) @(negedge clk);
        check("R9 all stopped", 64'({rx_stat, tx_stat}), 64'd0);
        rx_req = '1; tx_req = '1;
        for (int q = 0; q < NQ; q++) begin
            serve(1'b1, q, mk_ctx(1'b1, q, q != 2, (q == 3) ? 2'b01 : 2'b00, 1'b1), q < 2, 1'b0);
            serve(1'b0, q, mk_ctx(1'b0, q, 1'b1, 2'b00, q != 1), q != 1, 1'b0);
        end
        check("R8 rx errors", 64'(rx_err), 64'hC);
        check("R8 tx errors", 64'(tx_err), 64'h2);
        check("R8 rx status", 64'(rx_stat), 64'h3);
        check("R8 tx status", 64'(tx_stat), 64'hD);
        no_reads(4, "R8 no retry on error");
        rx_req[2] = 1'b0; rx_req[3] = 1'b0; tx_req[1] = 1'b0;
        @(negedge clk);
        check("R8 errors clear on release", 64'({rx_err, tx_err}), 64'd0);

        // R12 cancel during fetch
        tx_req = '0; rx_req = '0;
        repeat (2) @(negedge clk);
        tx_req[3] = 1'b1;
        begin
            bit seen;
            wait_rd(seen);
            check("R12 read issued", 64'(seen), 64'd1);
            rd_req_ready = 1'b1;
            @(negedge clk);
            rd_req_ready = 1'b0;
            tx_req[3] = 1'b0;
            @(negedge clk);
            rd_rsp_valid = 1'b1;
            rd_rsp_data = mk_ctx(1'b0, 3, 1'b1, 2'b00, 1'b1);
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            check("R12 discarded cfg", 64'(cfg_valid), 64'd0);
            check("R12 discarded status", 64'(tx_stat), 64'd0);
            check("R12 discarded error", 64'(tx_err), 64'd0);
        end
        tx_req[3] = 1'b1;
        serve(1'b0, 3, mk_ctx(1'b0, 3, 1'b1, 2'b00, 1'b1), 1'b1, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule